// File: doc/BRIEF.md
# Strobed Integer Clock Divider with Lock Flag

This block divides a single reference clock by a programmable integer ratio. It does not make a new clock. It makes a one-cycle clock-enable pulse, `tick_o`, once every N reference cycles. Logic downstream gates its registers with that pulse. One 32-bit control word is written and read as a whole word. It holds an output enable, a request for a reset of the downstream domain, an update strobe, a staged divider field and a read-only lock flag.

A divider value written to the field is only staged. The running ratio does not change until a write sets the update strobe. On that write the block takes in the new value, clears the lock flag and starts the new period from zero. The lock flag comes back once the first full period at the new ratio has ended. Software polls the flag to learn when the new ratio is in force.

A build option can forbid the ratios 1, 2 and 3. With it, a stored value of 1 or 2 becomes 0, which is a ratio of 1, and a stored 3 becomes 4. A second build option moves the lock flag to a lower bit of the word.

Top module: `clkdiv_lock_top`

## Requirements
- R1: After a synchronous reset, the control word reads with the enable at 0, the divider field at 0, the lock flag at 1 and every other bit at 0. `tick_o` and `dom_rst_o` are low.
- R2: Bit 0 of the control word is the output enable. While it is 0, `tick_o` stays low, although the counter keeps running.
- R3: With an effective ratio N, `tick_o` is high for one cycle in every N. A field value of 0 gives N = 1, the same as a value of 1. The largest ratio is the all-ones field.
- R4: The divider field occupies bits 4 and up, DIV_W bits wide, and reads back the value last stored. A write with bit 2 clear leaves the running ratio unchanged.
- R5: A write with bit 2 set loads the written field as the running ratio. It restarts the period count, and the lock flag reads 0 from the next cycle. The flag reads 1 again exactly N cycles after the write edge, which is within 4 x N.
- R6: Bit 2 is a strobe that clears itself. It always reads back as 0.
- R7: Writes to the lock flag have no effect. Writing a 1 there while a lock is pending leaves the flag at 0.
- R8: A write with bit 1 set drives `dom_rst_o` high for exactly RST_CYCLES cycles, starting in the cycle after the write. Bit 1 reads the state of `dom_rst_o`. A further request while the pulse is active is ignored, so the pulse never runs longer.
- R9: The lock flag is read at bit 31. It is read at bit 27 when LOCK_SHIFTED = 1.
- R10: When NO_LOW = 1, a written field of 1 or 2 is stored as 0 and a written 3 is stored as 4. Other values are stored unchanged.
- R11: After an update strobe, the first tick at the new ratio comes no sooner than N cycles after the last tick of the old ratio. A ratio change never produces a short period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Writes `wr_data` into the control word on this edge |
| wr_data | input | 32 | Full-word write data |
| rd_data | output | 32 | Current control word |
| tick_o | output | 1 | One-cycle clock-enable pulse, once per divided period |
| dom_rst_o | output | 1 | Reset pulse for the downstream domain |

## Verification
The bench measures lock latency down to the exact cycle for ratios 0, 1, mid values and 255. A design that kept the old period counter would lock late, and one that set the flag on the strobe itself would lock early. It changes the ratio mid-period, from 6 to 2, and measures the gap to the first new tick. A counter that carried on across the change would give a short period there.

It writes the field without the strobe and checks that the tick rate stays put. It also sends a second domain reset request inside an active pulse, which would stretch the pulse if it were honoured. It writes a 1 into the lock bit while a lock is pending. A second instance checks how the low ratios are remapped and checks the shifted lock position.

// File: rtl/cdv_pkg.sv
package cdv_pkg;

    localparam int unsigned CTL_EN_BIT   = 0;
    localparam int unsigned CTL_RST_BIT  = 1;
    localparam int unsigned CTL_UPD_BIT  = 2;
    localparam int unsigned CTL_DIV_LSB  = 4;
    localparam int unsigned LOCK_POS_STD = 31;
    localparam int unsigned LOCK_POS_ALT = 27;

    // Decoded command bits of one control write
    typedef struct packed {
        logic en;
        logic rst_req;
        logic upd;
    } ctl_cmd_t;

    function automatic int unsigned lock_pos(input int unsigned shifted);
        return (shifted != 0) ? LOCK_POS_ALT : LOCK_POS_STD;
    endfunction

    // Remap forbidden low ratios when the option is on
    function automatic logic [31:0] map_low(input logic [31:0] v, input int unsigned no_low);
        logic [31:0] r;
        r = v;
        if (no_low != 0) begin
            if (v == 32'd1 || v == 32'd2) r = 32'd0;
            else if (v == 32'd3)          r = 32'd4;
        end
        return r;
    endfunction

    function automatic ctl_cmd_t decode_cmd(input logic [31:0] w);
        ctl_cmd_t c;
        c.en      = w[CTL_EN_BIT];
        c.rst_req = w[CTL_RST_BIT];
        c.upd     = w[CTL_UPD_BIT];
        return c;
    endfunction

endpackage

// File: rtl/cdv_ctrl_reg.sv
module cdv_ctrl_reg
    import cdv_pkg::*;
#(
    parameter int unsigned DIV_W  = 8,
    parameter int unsigned NO_LOW = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    output logic              en_o,
    output logic [DIV_W-1:0]  field_o,
    output logic [DIV_W-1:0]  new_field_o,
    output logic              upd_o,
    output logic              rst_req_o
);

    ctl_cmd_t          cmd;
    logic [31:0]       raw32;
    logic [31:0]       map32;
    logic              en_q;
    logic [DIV_W-1:0]  field_q;
    logic              unused_bits;

    always_comb begin
        cmd   = decode_cmd(wr_data);
        raw32 = 32'(wr_data[CTL_DIV_LSB +: DIV_W]);
        map32 = map_low(raw32, NO_LOW);
    end

    assign new_field_o = map32[DIV_W-1:0];
    assign upd_o       = wr_en & cmd.upd;
    assign rst_req_o   = wr_en & cmd.rst_req;
    assign unused_bits = ^{wr_data, map32};

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= 1'b0;
            field_q <= '0;
        end else if (wr_en) begin
            en_q    <= cmd.en;
            field_q <= new_field_o;
        end
    end

    assign en_o    = en_q;
    assign field_o = field_q;

    generate
        if (NO_LOW != 0) begin : g_low_chk
            // R10
            low_ratio_absent_chk: assert property (@(posedge clk) disable iff (rst)
                (field_q != DIV_W'(1)) && (field_q != DIV_W'(2)) && (field_q != DIV_W'(3)));
        end
    endgenerate

endmodule

// File: rtl/cdv_tick_gen.sv
module cdv_tick_gen #(
    parameter int unsigned DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart_i,
    input  logic              en_i,
    input  logic [DIV_W-1:0]  div_i,
    output logic              boundary_o,
    output logic              tick_o
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] last_cnt;

    // A field of zero counts as a ratio of one
    assign last_cnt   = (div_i == '0) ? '0 : (div_i - DIV_W'(1));
    assign boundary_o = (cnt_q == last_cnt);
    assign tick_o     = boundary_o & en_i;

    always_ff @(posedge clk) begin
        if (rst)             cnt_q <= '0;
        else if (restart_i)  cnt_q <= '0;
        else if (boundary_o) cnt_q <= '0;
        else                 cnt_q <= cnt_q + DIV_W'(1);
    end

    // R3
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= last_cnt);

endmodule

// File: rtl/cdv_lock_seq.sv
module cdv_lock_seq #(
    parameter int unsigned DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_i,
    input  logic [DIV_W-1:0]  new_div_i,
    input  logic              boundary_i,
    output logic [DIV_W-1:0]  act_div_o,
    output logic              lock_o
);

    localparam int unsigned WAIT_W = DIV_W + 3;

    logic [DIV_W-1:0]  act_q;
    logic              lock_q;
    logic [WAIT_W-1:0] wait_q;
    logic [WAIT_W-1:0] wait_lim;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= '0;
            lock_q <= 1'b1;
        end else if (upd_i) begin
            act_q  <= new_div_i;
            lock_q <= 1'b0;
        end else if (boundary_i && !lock_q) begin
            lock_q <= 1'b1;
        end
    end

    assign act_div_o = act_q;
    assign lock_o    = lock_q;

    // Cycles spent waiting for lock, used only to bound the wait
    always_ff @(posedge clk) begin
        if (rst || upd_i)                  wait_q <= '0;
        else if (!lock_q && (&wait_q) == 1'b0) wait_q <= wait_q + WAIT_W'(1);
    end

    assign wait_lim = (act_q == '0) ? WAIT_W'(4) : (WAIT_W'(act_q) << 2);

    // R5
    lock_clear_chk: assert property (@(posedge clk) disable iff (rst)
        upd_i |=> !lock_o);

    // R5
    lock_window_chk: assert property (@(posedge clk) disable iff (rst)
        !lock_q |-> (wait_q < wait_lim));

endmodule

// File: rtl/cdv_rst_pulse.sv
module cdv_rst_pulse #(
    parameter int unsigned RST_CYCLES = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    output logic pulse_o
);

    localparam int unsigned CW = $clog2(RST_CYCLES + 1);

    logic [CW-1:0] left_q;
    logic [CW-1:0] len_q;

    assign pulse_o = (left_q != '0);

    always_ff @(posedge clk) begin
        if (rst)                   left_q <= '0;
        else if (req_i && !pulse_o) left_q <= CW'(RST_CYCLES);
        else if (pulse_o)          left_q <= left_q - CW'(1);
    end

    // Length of the current high run
    always_ff @(posedge clk) begin
        if (rst)            len_q <= '0;
        else if (pulse_o)   len_q <= len_q + CW'(1);
        else                len_q <= '0;
    end

    // R8
    pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
        len_q <= CW'(RST_CYCLES));

endmodule

// File: rtl/clkdiv_lock_top.sv
module clkdiv_lock_top
    import cdv_pkg::*;
#(
    parameter int unsigned DIV_W        = 8,
    parameter int unsigned LOCK_SHIFTED = 0,
    parameter int unsigned NO_LOW       = 0,
    parameter int unsigned RST_CYCLES   = 50
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        tick_o,
    output logic        dom_rst_o
);

    localparam int unsigned LOCK_POS = lock_pos(LOCK_SHIFTED);

    logic              en;
    logic [DIV_W-1:0]  field;
    logic [DIV_W-1:0]  new_field;
    logic              upd;
    logic              rst_req;
    logic [DIV_W-1:0]  act_div;
    logic              lock;
    logic              boundary;

    cdv_ctrl_reg #(.DIV_W(DIV_W), .NO_LOW(NO_LOW)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .en_o       (en),
        .field_o    (field),
        .new_field_o(new_field),
        .upd_o      (upd),
        .rst_req_o  (rst_req)
    );

    cdv_lock_seq #(.DIV_W(DIV_W)) u_lock (
        .clk       (clk),
        .rst       (rst),
        .upd_i     (upd),
        .new_div_i (new_field),
        .boundary_i(boundary),
        .act_div_o (act_div),
        .lock_o    (lock)
    );

    cdv_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk       (clk),
        .rst       (rst),
        .restart_i (upd),
        .en_i      (en),
        .div_i     (act_div),
        .boundary_o(boundary),
        .tick_o    (tick_o)
    );

    cdv_rst_pulse #(.RST_CYCLES(RST_CYCLES)) u_rst (
        .clk    (clk),
        .rst    (rst),
        .req_i  (rst_req),
        .pulse_o(dom_rst_o)
    );

    always_comb begin
        rd_data                          = '0;
        rd_data[CTL_EN_BIT]              = en;
        rd_data[CTL_RST_BIT]             = dom_rst_o;
        rd_data[CTL_DIV_LSB +: DIV_W]    = field;
        rd_data[LOCK_POS]                = lock;
    end

    // R4
    hold_ratio_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_data[CTL_UPD_BIT]) |=> (act_div == $past(act_div)));

    // R2
    en_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_data[CTL_EN_BIT] |-> !tick_o);

endmodule

// File: tb/clkdiv_lock_top_tb.sv
module clkdiv_lock_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data, rd2;
    logic        tick_o, tick2, dom_rst_o, dom_rst2;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int cyc = 0;
    int last_tick = 0;
    int last_gap = 0;

    always #10 clk = ~clk;

    clkdiv_lock_top u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .tick_o(tick_o), .dom_rst_o(dom_rst_o)
    );

    clkdiv_lock_top #(.NO_LOW(1), .LOCK_SHIFTED(1)) u_dut_alt (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd2), .tick_o(tick2), .dom_rst_o(dom_rst2)
    );

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (tick_o) begin
            last_gap  = cyc - last_tick;
            last_tick = cyc;
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] cmd(input bit en, input bit rq, input bit up, input int d);
        return {20'd0, 8'(d), 1'b0, up, rq, en};
    endfunction

    task automatic wr(input logic [31:0] v);
        step();
        wr_en   = 1'b1;
        wr_data = v;
        step();
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic t_reset();
        check(rd_data == 32'h8000_0000, "R1", rd_data, 32'h8000_0000);
        check(!tick_o && !dom_rst_o, "R1", {tick_o, dom_rst_o}, 0);
        check(rd2 == 32'h0800_0000, "R9", rd2, 32'h0800_0000);
    endtask

    // Strobe a ratio, check exact lock cycle and tick pattern
    task automatic t_ratio(input int d, input string tag);
        int r = (d == 0) ? 1 : d;
        int bad = 0;
        bit l_before = 1, l_after = 0;
        wr(cmd(1, 0, 1, d));
        check(rd_data[2] == 1'b0, "R6", rd_data[2], 0);
        for (int k = 0; k <= 3 * r; k++) begin
            if (k == r - 1) l_before = rd_data[31];
            if (k == r)     l_after  = rd_data[31];
            if (k < 3 * r && tick_o != ((k + 1) % r == 0)) bad++;
            step();
        end
        check(!l_before && l_after, "R5", {l_before, l_after}, 2'b01);
        check(bad == 0, tag, bad, 0);
    endtask

    task automatic t_enable_off();
        int n = 0;
        wr(cmd(1, 0, 1, 3));
        wr(cmd(0, 0, 0, 3));
        for (int k = 0; k < 12; k++) begin
            if (tick_o) n++;
            step();
        end
        check(n == 0, "R2", n, 0);
    endtask

    task automatic t_hold_field();
        int n = 0;
        wr(cmd(1, 0, 1, 3));
        wr(cmd(1, 0, 0, 9));
        check(rd_data[11:4] == 8'd9, "R4", rd_data[11:4], 9);
        for (int k = 0; k < 18; k++) begin
            if (tick_o) n++;
            step();
        end
        check(n == 6, "R4", n, 6);
        t_ratio(9, "R3");
    endtask

    task automatic t_lock_write();
        wr(cmd(1, 0, 1, 40));
        wr(cmd(1, 0, 0, 40) | 32'h8000_0000);
        check(rd_data[31] == 1'b0, "R7", rd_data[31], 0);
        repeat (45) step();
        check(rd_data[31] == 1'b1, "R5", rd_data[31], 1);
    endtask

    task automatic t_no_short();
        int t0;
        wr(cmd(1, 0, 1, 6));
        repeat (10) step();
        wr(cmd(1, 0, 1, 2));
        t0 = last_tick;
        for (int k = 0; k < 10 && last_tick == t0; k++) step();
        check(last_tick != t0 && last_gap >= 2, "R11", last_gap, 2);
    endtask

    task automatic t_dom_reset();
        int n = 0;
        wr(cmd(1, 1, 0, 2));
        check(rd_data[1] == 1'b1 && dom_rst_o, "R8", rd_data[1], 1);
        for (int k = 0; k < 70; k++) begin
            if (dom_rst_o) n++;
            if (k == 10) begin
                wr_en = 1'b1; wr_data = cmd(1, 1, 0, 2);
            end
            if (k == 11) begin
                wr_en = 1'b0; wr_data = '0;
            end
            step();
        end
        check(n == 50, "R8", n, 50);
        check(rd_data[1] == 1'b0, "R8", rd_data[1], 0);
    endtask

    task automatic t_low_map();
        wr(cmd(0, 0, 0, 1));
        check(rd2[11:4] == 8'd0, "R10", rd2[11:4], 0);
        check(rd_data[11:4] == 8'd1, "R10", rd_data[11:4], 1);
        wr(cmd(0, 0, 0, 2));
        check(rd2[11:4] == 8'd0, "R10", rd2[11:4], 0);
        wr(cmd(0, 0, 0, 3));
        check(rd2[11:4] == 8'd4, "R10", rd2[11:4], 4);
        wr(cmd(0, 0, 0, 5));
        check(rd2[11:4] == 8'd5, "R10", rd2[11:4], 5);
        wr(cmd(0, 0, 1, 20));
        check(rd2[27] == 1'b0 && rd2[31] == 1'b0, "R9", rd2, 0);
        repeat (25) step();
        check(rd2[27] == 1'b1, "R9", rd2[27], 1);
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        t_reset();
        t_ratio(0, "R3");
        t_ratio(1, "R3");
        t_ratio(5, "R3");
        t_ratio(7, "R3");
        t_ratio(255, "R3");
        t_enable_off();
        t_hold_field();
        t_lock_write();
        t_no_short();
        t_dom_reset();
        t_low_map();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #3_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule